// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface. After a synchronous reset it takes the memory through the start-up routine that the device needs before it accepts ordinary row activations. First it holds a long idle stretch, issuing only NOP commands, while the supply and clock settle. It then closes every bank with a precharge. Two auto-refresh cycles and the load of the mode register follow, in an order chosen by a parameter. Each command is followed by a minimum quiet gap before the next one.

Every wait is a number of clock cycles. The block derives each count at elaboration time from a clock-period parameter and a timing parameter in picoseconds. Throughout the routine the block keeps the clock enable high and all data-mask lines high, so the data bus stays undriven. When the last gap has run out it raises a completion flag. That flag stays high until the next reset, and from then on the normal controller may issue ACTIVE commands.

Top module: `sdram_init_seq`

## Requirements
- R1: From the first cycle after reset release, the command is NOP ({cs_n,ras_n,cas_n,we_n} = 0111) for exactly PWR_CYC cycles. No other command appears in that window, and init_done is low during reset and during the wait.
- R2: The first non-NOP command is PRECHARGE (0010). It appears in cycle PWR_CYC after release (counting the first released cycle as 0) with addr[10] = 1, which selects all banks.
- R3: The command after the precharge comes exactly RP_CYC cycles after it, and only NOP is driven in between.
- R4: Two AUTO REFRESH commands (0001) are issued. After each, the next command or completion comes exactly RFC_CYC cycles later, with NOP in between.
- R5: LOAD MODE (0000) drives addr = MODE_WORD zero-extended (bits above 10 are 0) and ba = 0. The next event comes exactly MRD_CYC cycles later (at least 1).
- R6: With MRS_FIRST = 0 the command order is PRECHARGE, REFRESH, REFRESH, LOAD MODE. With MRS_FIRST = 1 it is PRECHARGE, LOAD MODE, REFRESH, REFRESH. init_done rises in the cycle in which the gap of the fourth command expires.
- R7: Each cycle count is ceil(time_ps / CLK_PS), raised to 1 when that result is 0.
- R8: cke is 1 and every dqm bit is 1 in every cycle. After init_done only NOP is driven.
- R9: Once init_done is high it stays high until reset. A synchronous reset at any point drops init_done and restarts the whole routine from the power-up wait.
- R10: Exactly four non-NOP commands are issued per sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, restarts the routine |
| cke | output | 1 | SDRAM clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dqm | output | DQM_W | Data mask, all ones during the routine |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Row/column address, bit 10 selects all banks for precharge |
| init_done | output | 1 | High once the device may accept ACTIVE |

## Verification
A wrong step index or phase shows at once as the wrong command code, a wrong order, or address fields that do not belong to the command. A wrong gap or a counter that is off by one moves every later command by that amount. The event log exposes it at the next command edge, and in the end it moves the completion cycle. The power-up wait is the longest count, so an error there shows in the cycle of the precharge. An error in the completion logic shows in the first cycle the flag should change, or as stray commands after it.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  // Clock cycles covering a time in ps, never below one.
  function automatic int unsigned cyc_ceil(input longint unsigned t_ps,
                                           input longint unsigned clk_ps);
    longint unsigned q;
    q = (t_ps + clk_ps - 1) / clk_ps;
    if (q == 0) q = 1;
    return int'(q);
  endfunction

  // Command issued at each of the four sequence steps.
  function automatic sdr_cmd_e step_cmd(input logic [1:0] idx, input bit mrs_first);
    sdr_cmd_e c;
    case (idx)
      2'd0:    c = CMD_PRE;
      2'd1:    c = mrs_first ? CMD_MRS : CMD_REF;
      2'd2:    c = CMD_REF;
      default: c = mrs_first ? CMD_REF : CMD_MRS;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/init_timer.sv
module init_timer #(
  parameter int unsigned TW = 13
) (
  input  logic          clk,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (load)
      cnt <= load_val;
    else if (dec && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/init_cmd_drive.sv
module init_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BA_W      = 2,
  parameter logic [10:0] MODE_WORD = 11'h023
) (
  input  sdr_cmd_e          cmd,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  assign {cs_n, ras_n, cas_n, we_n} = cmd;

  always_comb begin
    addr = '0;
    ba   = '0;
    case (cmd)
      CMD_PRE: addr[10] = 1'b1;
      CMD_MRS: addr     = ADDR_W'(MODE_WORD);
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_PS    = 20000,
  parameter int unsigned PWRUP_PS  = 100_000_000,
  parameter int unsigned RP_PS     = 20000,
  parameter int unsigned RFC_PS    = 70000,
  parameter int unsigned MRD_CYC   = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned DQM_W     = 4,
  parameter logic [10:0] MODE_WORD = 11'h023,
  parameter bit          MRS_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [DQM_W-1:0]  dqm,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);
  localparam int unsigned PWR_CYC = cyc_ceil(PWRUP_PS, CLK_PS);
  localparam int unsigned RP_CYC  = cyc_ceil(RP_PS, CLK_PS);
  localparam int unsigned RFC_CYC = cyc_ceil(RFC_PS, CLK_PS);
  localparam int unsigned MRD_EFF = (MRD_CYC == 0) ? 1 : MRD_CYC;
  localparam int unsigned MAX_A   = (PWR_CYC > RP_CYC)  ? PWR_CYC : RP_CYC;
  localparam int unsigned MAX_B   = (RFC_CYC > MRD_EFF) ? RFC_CYC : MRD_EFF;
  localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TW      = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {PH_PWR, PH_ISSUE, PH_GAP, PH_DONE} phase_e;

  // Minimum command-to-next-event distance for a command.
  function automatic int unsigned gap_of(input sdr_cmd_e c);
    case (c)
      CMD_PRE: return RP_CYC;
      CMD_REF: return RFC_CYC;
      default: return MRD_EFF;
    endcase
  endfunction

  phase_e      phase;
  logic [1:0]  step;
  sdr_cmd_e    step_c;
  sdr_cmd_e    cur_cmd;
  int unsigned cur_gap;
  logic        tmr_load;
  logic [TW-1:0] tmr_val;
  logic        tmr_dec;
  logic        tmr_zero;

  // Named events for the checker
  logic in_pwr_wait;
  logic cmd_fire;
  logic last_step;
  logic gap_over;

  assign step_c      = step_cmd(step, MRS_FIRST);
  assign cur_gap     = gap_of(step_c);
  assign in_pwr_wait = (phase == PH_PWR);
  assign cmd_fire    = (phase == PH_ISSUE);
  assign last_step   = (step == 2'd3);
  assign gap_over    = (cmd_fire && cur_gap == 1) || (phase == PH_GAP && tmr_zero);
  assign cur_cmd     = cmd_fire ? step_c : CMD_NOP;

  assign tmr_load = rst || (cmd_fire && cur_gap > 1);
  assign tmr_val  = rst ? TW'(PWR_CYC - 1) : TW'(cur_gap - 2);
  assign tmr_dec  = (phase == PH_PWR) || (phase == PH_GAP);

  init_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_PWR;
      step  <= 2'd0;
    end else begin
      case (phase)
        PH_PWR:   if (tmr_zero) phase <= PH_ISSUE;
        PH_ISSUE: if (cur_gap > 1) phase <= PH_GAP;
        PH_GAP:   ;
        default:  ;
      endcase
      if (gap_over) begin
        if (last_step) begin
          phase <= PH_DONE;
        end else begin
          phase <= PH_ISSUE;
          step  <= step + 2'd1;
        end
      end
    end
  end

  init_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_WORD(MODE_WORD)) u_drive (
    .cmd   (cur_cmd),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .addr  (addr),
    .ba    (ba)
  );

  assign cke       = 1'b1;
  assign dqm       = '1;
  assign init_done = (phase == PH_DONE);
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned PWR_CYC   = 1,
  parameter int unsigned RFC_CYC   = 1,
  parameter int unsigned MRD_EFF   = 1,
  parameter logic [10:0] MODE_WORD = 11'h0
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              init_done,
  input logic              in_pwr_wait
);
  logic [3:0]  cmd;
  logic [31:0] since;
  logic [2:0]  n_cmd;

  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      n_cmd <= '0;
    end else begin
      if (since != 32'hFFFF_FFFF) since <= since + 1;
      if (cmd != 4'b0111 && n_cmd != 3'd7) n_cmd <= n_cmd + 3'd1;
    end
  end

  // R1
  pwr_nop_chk: assert property (@(posedge clk) disable iff (rst)
    in_pwr_wait |-> cmd == 4'b0111);

  // R1
  pwr_window_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd != 4'b0111) |-> since >= PWR_CYC);

  // R2
  pre_all_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010) |-> addr[10]);

  // R4
  ref_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0001 && RFC_CYC > 1) |=> cmd == 4'b0111);

  // R5
  mrs_field_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> (ba == '0 && addr == ADDR_W'(MODE_WORD)));

  // R5
  mrs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000 && MRD_EFF > 1) |=> cmd == 4'b0111);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |-> cmd == 4'b0111);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R10
  cmd_count_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |-> n_cmd == 3'd4);
endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .PWR_CYC(PWR_CYC), .RFC_CYC(RFC_CYC),
  .MRD_EFF(MRD_EFF), .MODE_WORD(MODE_WORD)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .addr(addr), .ba(ba), .init_done(init_done), .in_pwr_wait(in_pwr_wait)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
  localparam int CLK_PS = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10ns clk = ~clk;

  logic        cke   [2];
  logic        cs_n  [2];
  logic        ras_n [2];
  logic        cas_n [2];
  logic        we_n  [2];
  logic [3:0]  dqm   [2];
  logic [1:0]  ba    [2];
  logic [11:0] addr  [2];
  logic        done  [2];

  sdram_init_seq dut (
    .clk(clk), .rst(rst), .cke(cke[0]), .cs_n(cs_n[0]), .ras_n(ras_n[0]),
    .cas_n(cas_n[0]), .we_n(we_n[0]), .dqm(dqm[0]), .ba(ba[0]), .addr(addr[0]),
    .init_done(done[0])
  );

  sdram_init_seq #(
    .CLK_PS(CLK_PS), .PWRUP_PS(2_000_000), .RP_PS(45000), .RFC_PS(0),
    .MRD_CYC(3), .MODE_WORD(11'h032), .MRS_FIRST(1'b1)
  ) dut_mf (
    .clk(clk), .rst(rst), .cke(cke[1]), .cs_n(cs_n[1]), .ras_n(ras_n[1]),
    .cas_n(cas_n[1]), .we_n(we_n[1]), .dqm(dqm[1]), .ba(ba[1]), .addr(addr[1]),
    .init_done(done[1])
  );

  int checks = 0;
  int errors = 0;

  // Event log per instance
  int          k;
  int          ev_n     [2];
  logic [3:0]  ev_cmd   [2][8];
  int          ev_cyc   [2][8];
  logic [11:0] ev_addr  [2][8];
  logic [1:0]  ev_ba    [2][8];
  int          done_cyc [2];
  int          bad_pins [2];
  int          done_fell[2];
  logic        prev_done[2];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    for (int i = 0; i < 2; i++) begin
      ev_n[i] = 0; done_cyc[i] = -1; bad_pins[i] = 0; done_fell[i] = 0;
      prev_done[i] = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      k = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        logic [3:0] c;
        c = {cs_n[i], ras_n[i], cas_n[i], we_n[i]};
        if (c != 4'b0111) begin
          if (ev_n[i] < 8) begin
            ev_cmd[i][ev_n[i]] = c; ev_cyc[i][ev_n[i]] = k;
            ev_addr[i][ev_n[i]] = addr[i]; ev_ba[i][ev_n[i]] = ba[i];
          end
          ev_n[i]++;
        end
        if (cke[i] !== 1'b1 || dqm[i] !== 4'hF) bad_pins[i]++;
        if (done[i] && done_cyc[i] < 0) done_cyc[i] = k;
        if (prev_done[i] && !done[i]) done_fell[i]++;
        if (!done[i] && k < 5000 + 100 && done_cyc[i] >= 0) done_fell[i]++;
        prev_done[i] = done[i];
      end
      k++;
    end
  end

  function automatic int bcyc(input longint t, input longint p);
    int r;
    r = int'(t / p) + ((t % p) != 0 ? 1 : 0);
    return (r < 1) ? 1 : r;
  endfunction

  task automatic release_rst();
    @(posedge clk); #1 rst = 1'b0;
  endtask

  task automatic wait_done();
    while (!(done[0] && done[1])) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // R1 R8 R9: values while reset is held
  task automatic t_reset_state();
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk({cs_n[i], ras_n[i], cas_n[i], we_n[i]} == 4'b0111, "R1", "reset cmd",
          {cs_n[i], ras_n[i], cas_n[i], we_n[i]}, 4'b0111);
      chk(cke[i] == 1'b1 && dqm[i] == 4'hF, "R8", "reset cke/dqm",
          {cke[i], dqm[i]}, 5'h1F);
      chk(done[i] == 1'b0, "R9", "done in reset", done[i], 0);
    end
  endtask

  // R2..R8 R10: full command log against bench-computed timing
  task automatic t_sequence(input int i, input longint pwr_ps, input longint rp_ps,
                            input longint rfc_ps, input int mrd, input logic [10:0] mode,
                            input bit mrs_first, input string tag);
    logic [3:0] exp_c [4];
    int c, g;
    exp_c[0] = 4'b0010;
    exp_c[1] = mrs_first ? 4'b0000 : 4'b0001;
    exp_c[2] = 4'b0001;
    exp_c[3] = mrs_first ? 4'b0001 : 4'b0000;
    c = bcyc(pwr_ps, CLK_PS);
    chk(ev_n[i] == 4, "R10", {tag, " command count"}, ev_n[i], 4);
    for (int j = 0; j < 4 && j < ev_n[i]; j++) begin
      chk(ev_cmd[i][j] == exp_c[j], "R6", {tag, " command order"}, ev_cmd[i][j], exp_c[j]);
      // R1 R3 R4 R5 R7: issue cycle
      chk(ev_cyc[i][j] == c, j == 0 ? "R2" : "R7", {tag, " issue cycle"}, ev_cyc[i][j], c);
      if (exp_c[j] == 4'b0010) begin
        chk(ev_addr[i][j][10] == 1'b1, "R2", {tag, " precharge A10"}, ev_addr[i][j][10], 1);
        g = bcyc(rp_ps, CLK_PS);
      end else if (exp_c[j] == 4'b0001) begin
        g = bcyc(rfc_ps, CLK_PS);
      end else begin
        chk(ev_addr[i][j] == {1'b0, mode} && ev_ba[i][j] == 2'b00, "R5",
            {tag, " mode fields"}, {ev_ba[i][j], ev_addr[i][j]}, {2'b00, 1'b0, mode});
        g = (mrd < 1) ? 1 : mrd;
      end
      c += g;
    end
    chk(done_cyc[i] == c, mrs_first ? "R6" : "R5", {tag, " done cycle"}, done_cyc[i], c);
    chk(bad_pins[i] == 0, "R8", {tag, " cke/dqm"}, bad_pins[i], 0);
    chk(done_fell[i] == 0, "R9", {tag, " done sticky"}, done_fell[i], 0);
  endtask

  task automatic t_both(input string tag);
    t_sequence(0, 100_000_000, 20000, 70000, 2, 11'h023, 1'b0, {tag, " dflt"});
    t_sequence(1, 2_000_000, 45000, 0, 3, 11'h032, 1'b1, {tag, " mf"});
  endtask

  // R9: reset after completion and again in the middle of the wait
  task automatic t_restart();
    repeat (20) @(negedge clk);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(done[0] == 1'b0 && done[1] == 1'b0, "R9", "done cleared by reset",
        {done[0], done[1]}, 0);
    clear_logs();
    release_rst();
    repeat (40) @(negedge clk);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1;
    clear_logs();
    release_rst();
    wait_done();
    t_both("R9 restart");
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_logs();
    repeat (3) @(posedge clk);
    t_reset_state();
    clear_logs();
    release_rst();
    wait_done();
    t_both("first");
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule